// File: doc/BRIEF.md
# Reload timer unit

A bank of independent down-counting timer channels reached through a small register bus. Each channel owns a count register, a reload (constant) register and a 16-bit control word. One byte-wide start register, shared by all channels, holds a run bit per channel. A running channel divides the clock by a selectable prescale ratio. It decrements its count on every prescaled tick. When it ticks at zero it reloads from its constant register and sets a sticky underflow flag.

The flag drives the channel's interrupt line when the channel's interrupt enable is set. Software clears the flag by writing the control word with the flag bit at 0. Because the count is written separately from the constant, software can set the delay to the first event apart from the repeat period. Loading all-ones into both registers gives the longest period, and the bit-inverted count then reads as a free-running up counter.

The bus is write-strobe plus address, with read data driven combinationally from the address. The reset input is asynchronous and active-low. Its release is synchronised inside the block.

Top module: `reload_timer_unit`

## Requirements
- R1: After reset every register reads 0 (start, and for each channel constant, count and control) and all interrupt lines are low.
- R2: A channel whose run bit is 1 decreases its count by exactly one on each prescaled tick, and by no more.
- R3: On a tick with the count at 0, the channel loads the count from its constant register and sets its underflow flag, which is control bit 8.
- R4: Control bits [2:0] set the prescale ratio: 000 gives 4 clocks, 001 gives 16, 010 gives 64 and 011 gives 256, and every other code gives 4. The first decrement comes exactly one ratio of clock edges after the edge that sets the run bit.
- R5: The start register is at address 0x00 and bit n is the run bit of channel n. A write stores the low NUM_CH bits as given. Bits at NUM_CH and above read as 0. Changing one channel's bit by read-modify-write leaves the other bits unchanged.
- R6: Control bit 5 is the interrupt enable. irq[n] is high exactly while channel n has both its flag and its enable set, and it stays high until the control word is written.
- R7: A control write with bit 8 at 0 clears the flag. A write with bit 8 at 1 neither sets nor clears it. Writing 0x0020 clears the flag and keeps the enable, and writing 0x0000 clears both. An underflow in the same cycle as a clearing write leaves the flag set.
- R8: With its run bit at 0, a channel holds its count and resets its prescaler phase, so after a restart the next decrement again comes one full ratio later.
- R9: The count register can be written apart from the constant register. The first underflow follows the written count, and later periods follow the constant.
- R10: With all-ones in the count and constant registers, the bit-inverted count equals the number of ticks since start.
- R11: Channels run independently. Each has its own run bit, prescaler, flag and interrupt line.
- R12: Channel n sits at base 0x10 + 0x10*n, with the constant at +0x0, the count at +0x4 and the control word at +0x8. Reads of any other address return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_addr | input | ADDR_W (8) | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | NUM_CH (3) | Per-channel interrupt lines |

## Verification
The bench builds the block with its defaults: three channels, 32-bit counters and an 8-bit address. With three channels the unused start bits 3 to 7 and the unmapped fourth channel slot are reachable, so the zero readback and the ignored writes can be tested. Because the counter is 32 bits wide and loadable, the all-ones long-period case and the inverted up-count are reached within a few dozen cycles. The largest prescale ratio of 256 keeps every ratio boundary, checked one edge before and at the decrement, inside a short run.

// File: rtl/rtu_pkg.sv
package rtu_pkg;
  localparam int unsigned BUS_W   = 32;
  localparam int unsigned CTRL_W  = 16;
  localparam int unsigned PSC_W   = 8;
  localparam int unsigned OFS_CONST = 'h0;
  localparam int unsigned OFS_COUNT = 'h4;
  localparam int unsigned OFS_CTRL  = 'h8;
  localparam int unsigned BIT_IE  = 5;
  localparam int unsigned BIT_UF  = 8;

  typedef struct packed {
    logic       uf;
    logic       ie;
    logic [2:0] psc;
  } ctrl_t;

  // last phase value of the prescaler for a given ratio code
  function automatic logic [PSC_W-1:0] psc_last(input logic [2:0] code);
    case (code)
      3'd1:    return PSC_W'(15);
      3'd2:    return PSC_W'(63);
      3'd3:    return PSC_W'(255);
      default: return PSC_W'(3);
    endcase
  endfunction

  function automatic logic [CTRL_W-1:0] ctrl_pack(input ctrl_t c);
    logic [CTRL_W-1:0] r;
    r = '0;
    r[BIT_UF] = c.uf;
    r[BIT_IE] = c.ie;
    r[2:0]    = c.psc;
    return r;
  endfunction
endpackage

// File: rtl/rtu_prescaler.sv
module rtu_prescaler
  import rtu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [2:0] code,
  output logic       tick
);
  logic [PSC_W-1:0] ph_q, ph_d, last;

  always_comb begin
    last = psc_last(code);
    tick = run && (ph_q >= last);
    if (!run || tick) ph_d = '0;
    else              ph_d = ph_q + PSC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end
endmodule

// File: rtl/rtu_channel.sv
module rtu_channel
  import rtu_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              wr_const,
  input  logic              wr_count,
  input  logic              wr_ctrl,
  input  logic [BUS_W-1:0]  wdata,
  output logic [CNT_W-1:0]  count_q,
  output logic [CNT_W-1:0]  reload_q,
  output logic [CTRL_W-1:0] ctrl_rd,
  output logic              tick,
  output logic              uf_flag,
  output logic              irq
);
  ctrl_t            ctl_q, ctl_d;
  logic [CNT_W-1:0] cnt_d, rel_d;
  logic             underflow;

  rtu_prescaler u_psc (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .code (ctl_q.psc),
    .tick (tick)
  );

  always_comb begin
    underflow = tick && !wr_count && (count_q == '0);
    rel_d     = wr_const ? wdata[CNT_W-1:0] : reload_q;

    cnt_d = count_q;
    if (wr_count)      cnt_d = wdata[CNT_W-1:0];
    else if (underflow) cnt_d = reload_q;
    else if (tick)      cnt_d = count_q - CNT_W'(1);

    ctl_d = ctl_q;
    if (wr_ctrl) begin
      ctl_d.ie  = wdata[BIT_IE];
      ctl_d.psc = wdata[2:0];
      if (!wdata[BIT_UF]) ctl_d.uf = 1'b0;
    end
    if (underflow) ctl_d.uf = 1'b1;   // a new event beats a clearing write
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q  <= '0;
      reload_q <= '0;
      ctl_q    <= '0;
    end else begin
      count_q  <= cnt_d;
      reload_q <= rel_d;
      ctl_q    <= ctl_d;
    end
  end

  assign ctrl_rd = ctrl_pack(ctl_q);
  assign uf_flag = ctl_q.uf;
  assign irq     = ctl_q.uf & ctl_q.ie;
endmodule

// File: rtl/rtu_regbank.sv
module rtu_regbank
  import rtu_pkg::*;
#(
  parameter int unsigned NUM_CH     = 3,
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned START_ADDR = 'h00,
  parameter int unsigned CH_BASE    = 'h10,
  parameter int unsigned CH_STRIDE  = 'h10
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                bus_wr,
  input  logic [ADDR_W-1:0]                   bus_addr,
  input  logic [NUM_CH-1:0]                   run_wdata,
  input  logic [NUM_CH-1:0][CNT_W-1:0]        ch_count,
  input  logic [NUM_CH-1:0][CNT_W-1:0]        ch_reload,
  input  logic [NUM_CH-1:0][CTRL_W-1:0]       ch_ctrl,
  output logic [NUM_CH-1:0]                   run_q,
  output logic [NUM_CH-1:0]                   wr_const,
  output logic [NUM_CH-1:0]                   wr_count,
  output logic [NUM_CH-1:0]                   wr_ctrl,
  output logic [BUS_W-1:0]                    bus_rdata
);
  localparam logic [ADDR_W-1:0] A_START = ADDR_W'(START_ADDR);

  logic [NUM_CH-1:0]            run_d;
  logic                         start_hit;
  logic [NUM_CH-1:0][BUS_W-1:0] rd_part;

  assign start_hit = (bus_addr == A_START);

  always_comb begin
    run_d = run_q;
    if (bus_wr && start_hit) run_d = run_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end

  for (genvar n = 0; n < NUM_CH; n++) begin : g_dec
    localparam logic [ADDR_W-1:0] A_CONST = ADDR_W'(CH_BASE + n*CH_STRIDE + OFS_CONST);
    localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(CH_BASE + n*CH_STRIDE + OFS_COUNT);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(CH_BASE + n*CH_STRIDE + OFS_CTRL);

    assign wr_const[n] = bus_wr && (bus_addr == A_CONST);
    assign wr_count[n] = bus_wr && (bus_addr == A_COUNT);
    assign wr_ctrl[n]  = bus_wr && (bus_addr == A_CTRL);

    assign rd_part[n] = (bus_addr == A_CONST) ? BUS_W'(ch_reload[n]) :
                        (bus_addr == A_COUNT) ? BUS_W'(ch_count[n])  :
                        (bus_addr == A_CTRL)  ? BUS_W'(ch_ctrl[n])   : '0;
  end

  always_comb begin
    bus_rdata = start_hit ? BUS_W'(run_q) : '0;
    for (int n = 0; n < NUM_CH; n++) bus_rdata = bus_rdata | rd_part[n];
  end
endmodule

// File: rtl/reload_timer_unit.sv
module reload_timer_unit
  import rtu_pkg::*;
#(
  parameter int unsigned NUM_CH     = 3,   // at most 8: one start byte
  parameter int unsigned CNT_W      = 32,  // at most BUS_W
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned START_ADDR = 'h00,
  parameter int unsigned CH_BASE    = 'h10,
  parameter int unsigned CH_STRIDE  = 'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic [NUM_CH-1:0] irq
);
  logic rst_meta_q, rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q_n    <= rst_meta_q;
    end
  end

  logic [NUM_CH-1:0]              run_vec, tick_vec, uf_vec;
  logic [NUM_CH-1:0]              wr_const_vec, wr_count_vec, wr_ctrl_vec;
  logic [NUM_CH-1:0][CNT_W-1:0]   count_arr, reload_arr;
  logic [NUM_CH-1:0][CTRL_W-1:0]  ctrl_arr;

  rtu_regbank #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W),
    .START_ADDR(START_ADDR), .CH_BASE(CH_BASE), .CH_STRIDE(CH_STRIDE)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .run_wdata(bus_wdata[NUM_CH-1:0]),
    .ch_count (count_arr),
    .ch_reload(reload_arr),
    .ch_ctrl  (ctrl_arr),
    .run_q    (run_vec),
    .wr_const (wr_const_vec),
    .wr_count (wr_count_vec),
    .wr_ctrl  (wr_ctrl_vec),
    .bus_rdata(bus_rdata)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    rtu_channel #(.CNT_W(CNT_W)) u_ch (
      .clk     (clk),
      .rst_n   (rst_q_n),
      .run     (run_vec[n]),
      .wr_const(wr_const_vec[n]),
      .wr_count(wr_count_vec[n]),
      .wr_ctrl (wr_ctrl_vec[n]),
      .wdata   (bus_wdata),
      .count_q (count_arr[n]),
      .reload_q(reload_arr[n]),
      .ctrl_rd (ctrl_arr[n]),
      .tick    (tick_vec[n]),
      .uf_flag (uf_vec[n]),
      .irq     (irq[n])
    );
  end
endmodule

// File: rtl/rtu_checker.sv
module rtu_checker #(
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned CNT_W  = 32
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [NUM_CH-1:0]           run,
  input logic [NUM_CH-1:0]           tick,
  input logic [NUM_CH-1:0]           wr_const,
  input logic [NUM_CH-1:0]           wr_count,
  input logic [NUM_CH-1:0]           wr_ctrl,
  input logic [NUM_CH-1:0][CNT_W-1:0] count,
  input logic [NUM_CH-1:0][CNT_W-1:0] reload,
  input logic [NUM_CH-1:0]           uf,
  input logic [NUM_CH-1:0]           irq
);
  for (genvar n = 0; n < NUM_CH; n++) begin : g_prop
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (run[n] && !wr_count[n] && count[n] != '0) |=>
        (count[n] == $past(count[n]) || count[n] == $past(count[n]) - CNT_W'(1)));

    p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick[n] && !wr_count[n] && !wr_const[n] && count[n] == '0) |=>
        (count[n] == $past(reload[n]) && uf[n]));

    p_tick_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tick[n] |=> !tick[n]);

    p_irq_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq[n] && !wr_ctrl[n]) |=> irq[n]);

    p_flag_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(uf[n]) |-> ($past(tick[n]) && $past(count[n]) == '0 && !$past(wr_count[n])));

    p_hold_stopped_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!run[n] && !wr_count[n]) |=> $stable(count[n]));
  end
endmodule

bind reload_timer_unit rtu_checker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_q_n),
  .run     (run_vec),
  .tick    (tick_vec),
  .wr_const(wr_const_vec),
  .wr_count(wr_count_vec),
  .wr_ctrl (wr_ctrl_vec),
  .count   (count_arr),
  .reload  (reload_arr),
  .uf      (uf_vec),
  .irq     (irq)
);

// File: tb/tb_reload_timer_unit.sv
module tb_reload_timer_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [2:0]  irq;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  reload_timer_unit dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  localparam logic [7:0] A_START = 8'h00;

  function automatic logic [7:0] a_const(input int ch); return 8'(8'h10 + ch*16);     endfunction
  function automatic logic [7:0] a_count(input int ch); return 8'(8'h10 + ch*16 + 4); endfunction
  function automatic logic [7:0] a_ctrl (input int ch); return 8'(8'h10 + ch*16 + 8); endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // called at a falling edge; the write lands on the next rising edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic chk_reg(input string req, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk_reg("R1 start", A_START, 0);
    for (int c = 0; c < 3; c++) begin
      chk_reg("R1 const", a_const(c), 0);
      chk_reg("R1 count", a_count(c), 0);
      chk_reg("R1 ctrl",  a_ctrl(c),  0);
    end
    check("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_count_down;
    wr(a_count(0), 10);
    wr(a_const(0), 10);
    wr(a_ctrl(0), 0);
    wr(a_count(1), 77);
    wr(A_START, 32'h1);
    edges(12);
    chk_reg("R2 three ticks at /4", a_count(0), 7);
    chk_reg("R2 stopped channel holds", a_count(1), 77);
    wr(A_START, 0);
  endtask

  task automatic t_reload_irq;
    wr(a_count(0), 2);
    wr(a_const(0), 5);
    wr(a_ctrl(0), 32'h20);
    wr(A_START, 32'h1);
    edges(11);
    chk_reg("R9 count reaches zero first", a_count(0), 0);
    check("R6 no irq before underflow", 32'(irq), 0);
    edges(1);
    chk_reg("R3 reload from constant", a_count(0), 5);
    chk_reg("R3 flag bit 8 set", a_ctrl(0), 32'h120);
    check("R6 irq raised", 32'(irq), 32'h1);
    edges(2);
    check("R6 irq held", 32'(irq), 32'h1);
    wr(a_ctrl(0), 32'h20);
    chk_reg("R7 0x0020 clears flag keeps enable", a_ctrl(0), 32'h20);
    check("R7 irq dropped", 32'(irq), 0);
    wr(A_START, 0);
    wr(a_ctrl(0), 0);
    chk_reg("R7 0x0000 clears enable", a_ctrl(0), 0);
  endtask

  task automatic t_prescale;
    logic [2:0] codes [4] = '{3'd1, 3'd2, 3'd3, 3'd5};
    int         ratio [4] = '{16, 64, 256, 4};
    for (int i = 0; i < 4; i++) begin
      wr(a_ctrl(0), 32'(codes[i]));
      wr(a_count(0), 100);
      wr(A_START, 32'h1);
      edges(ratio[i] - 1);
      chk_reg("R4 no decrement before ratio", a_count(0), 100);
      edges(1);
      chk_reg("R4 decrement at ratio", a_count(0), 99);
      wr(A_START, 0);
    end
    wr(a_ctrl(0), 0);
  endtask

  task automatic t_start_reg;
    wr(A_START, 32'h2);
    chk_reg("R5 single bit", A_START, 32'h2);
    wr(A_START, 32'h2 | 32'h1);
    chk_reg("R5 rmw keeps other bit", A_START, 32'h3);
    wr(A_START, 32'hFF);
    chk_reg("R5 unused bits read 0", A_START, 32'h7);
    wr(A_START, 32'h7 & ~32'h4);
    chk_reg("R5 rmw clear one bit", A_START, 32'h3);
    wr(A_START, 0);
  endtask

  task automatic t_stop_restart;
    wr(a_count(0), 50);
    wr(A_START, 32'h1);
    edges(6);
    chk_reg("R2 one tick", a_count(0), 49);
    wr(A_START, 0);
    edges(10);
    chk_reg("R8 count held while stopped", a_count(0), 49);
    wr(A_START, 32'h1);
    edges(3);
    chk_reg("R8 phase restarted, no early tick", a_count(0), 49);
    edges(1);
    chk_reg("R8 full ratio after restart", a_count(0), 48);
    wr(A_START, 0);
  endtask

  task automatic t_free_run;
    wr(a_count(0), 32'hFFFF_FFFF);
    wr(a_const(0), 32'hFFFF_FFFF);
    wr(A_START, 32'h1);
    edges(40);
    bus_addr = a_count(0);
    #1;
    check("R10 inverted count is up count", bus_rdata ^ 32'hFFFF_FFFF, 10);
    wr(A_START, 0);
  endtask

  task automatic t_multi;
    wr(a_count(1), 0);
    wr(a_const(1), 3);
    wr(a_ctrl(1), 32'h20);
    wr(a_count(2), 0);
    wr(a_const(2), 3);
    wr(a_ctrl(2), 0);
    wr(A_START, 32'h6);
    edges(4);
    check("R11 only enabled channel interrupts", 32'(irq), 32'h2);
    chk_reg("R11 flag without enable", a_ctrl(2), 32'h100);
    chk_reg("R11 channel 0 untouched", a_count(0), 32'hFFFF_FFF5);
    wr(a_ctrl(2), 32'h100);
    chk_reg("R7 writing bit 8 as 1 keeps flag", a_ctrl(2), 32'h100);
    wr(a_ctrl(2), 0);
    chk_reg("R7 writing bit 8 as 0 clears", a_ctrl(2), 0);
    wr(a_ctrl(2), 32'h120);
    chk_reg("R7 writing bit 8 as 1 does not set", a_ctrl(2), 32'h20);
    check("R6 irq follows flag and enable", 32'(irq), 32'h2);
    wr(A_START, 0);
    wr(a_ctrl(1), 0);
    wr(a_ctrl(2), 0);
    check("R6 irq cleared", 32'(irq), 0);
  endtask

  task automatic t_unmapped;
    wr(8'h0C, 32'hDEAD_BEEF);
    chk_reg("R12 gap reads 0", 8'h0C, 0);
    wr(8'h48, 32'h0000_0123);
    chk_reg("R12 slot past last channel reads 0", 8'h48, 0);
    chk_reg("R12 ch0 ctrl unchanged", a_ctrl(0), 0);
    chk_reg("R12 ch2 ctrl unchanged", a_ctrl(2), 0);
    chk_reg("R12 start unchanged", A_START, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    edges(3);
    t_reset();
    t_count_down();
    t_reload_irq();
    t_prescale();
    t_start_reg();
    t_stop_restart();
    t_free_run();
    t_multi();
    t_unmapped();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule